// File: doc/BRIEF.md
# Serial Debug Request Address Resolver

This block sits on the target side of a two-wire serial debug link. It watches the sampled data line one bit per clock and waits in an idle state for a start bit. It then collects the rest of an 8-bit request header and checks the framing and the even parity. From the header it decodes which port type is addressed (debug port or access port), the transfer direction and a two-bit register offset.

Only two address bits travel in the header. Address bits 1:0 are implied zero. The upper nibble of the full address comes from a bank field of a 32-bit bank-select register held inside the block. The debug-port bank field is used for debug-port requests and the access-port bank field for access-port requests. Each correct header produces a registered, resolved address together with the port type, the direction and the access-port number, plus a one-cycle valid strobe. A malformed header produces a one-cycle error strobe instead.

The bank-select register is written through a 32-bit load port. A load is accepted only while the most recent completed header was a correct debug-port write to offset 0x8. The register's current value is visible on an output.

The receiver is a state machine with eight states: `ST_IDLE`, `ST_PORT`, `ST_DIR`, `ST_A2`, `ST_A3`, `ST_PAR`, `ST_STOP` and `ST_PARK`. `ST_IDLE` stays put while the line is 0 and moves to `ST_PORT` when the line is 1 (the start bit). Each collecting state moves to the next one after exactly one clock. `ST_PARK` always returns to `ST_IDLE`, and the header is judged on that transition.

Top module: `sdbg_req_resolver`

## Requirements
- R1: The header bits arrive in this time order: start, port type, direction, A2, A3, parity, stop, park. Port type 1 means access port and 0 means debug port. Direction 1 means read and 0 means write. A2 arrives before A3, so offset 0x8 is carried as A2=0 then A3=1. The resolved offset is {A3, A2, 2'b00}.
- R2: After reset, the bank-select register reads 0. Valid, error, address, port type, direction and access-port number are all 0. Debug-port requests then resolve to 0x00, 0x04, 0x08 and 0x0C.
- R3: A debug-port request resolves to {select[3:0], A3, A2, 2'b00}.
- R4: An access-port request resolves to {select[7:4], A3, A2, 2'b00}. Every correct request also outputs select[31:24] as the access-port number.
- R5: The parity bit must make the count of ones across port type, direction, A2, A3 and parity even. Otherwise the error strobe rises and the valid strobe does not.
- R6: The stop bit must be 0 and the park bit must be 1. Otherwise the error strobe rises and the valid strobe does not.
- R7: While idle, 0 bits on the line are ignored and raise no strobe. A 1 starts a new header.
- R8: The address, port type, direction and access-port number change only when the valid strobe is raised. They hold through errors and through bank-select loads.
- R9: A load takes effect on the next clock edge only if the last completed header was a correct debug-port write to offset 0x8. Any other last header, including an error, blocks the load. Bits 23:8 of the bank-select register always read 0.
- R10: The valid or error strobe is high for exactly one cycle, in the cycle after the park bit is sampled. The two strobes are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| swdio_in | input | 1 | Sampled serial data line |
| sel_ld | input | 1 | Bank-select load request |
| sel_wdata | input | 32 | Bank-select load data |
| req_valid | output | 1 | One-cycle strobe for a correct header |
| req_err | output | 1 | One-cycle strobe for a malformed header |
| req_is_ap | output | 1 | 1 = access-port request |
| req_is_read | output | 1 | 1 = read request |
| req_addr | output | 8 | Resolved register address |
| req_apsel | output | 8 | Access-port number |
| sel_q | output | 32 | Current bank-select register value |

## Verification
The hardest situation to reach is a combination of bank values and header fields that would expose a swapped nibble, a swapped address bit or the wrong bank for a port type. The stimulus reaches it by sweeping all sixteen debug-port bank values. Each sweep step pairs the debug-port bank with the complementary access-port bank and sends all sixteen combinations of port type, direction, A2 and A3. Load gating is also hard to see from outside, so loads are attempted after several kinds of last header: a read, an access-port write, a write to the wrong offset, and a good write followed by an error. After each attempt the register readback shows whether the load was taken.

// File: rtl/sdbg_pkg.sv
package sdbg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PORT,
        ST_DIR,
        ST_A2,
        ST_A3,
        ST_PAR,
        ST_STOP,
        ST_PARK
    } rx_state_e;

    typedef struct packed {
        logic       is_ap;
        logic       is_read;
        logic [1:0] ofs;     // {A3, A2}
    } req_hdr_t;

    localparam logic [1:0] SEL_OFS = 2'b10;   // offset 0x8 in word units

endpackage

// File: rtl/sdbg_hdr_rx.sv
module sdbg_hdr_rx
    import sdbg_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     din,
    output logic     fin_ok,
    output logic     fin_err,
    output req_hdr_t hdr
);

    rx_state_e state_q;
    rx_state_e state_d;
    logic      par_q;
    logic      stop_q;
    logic      frame_good;
    logic      parity_good;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (din) state_d = ST_PORT;
            ST_PORT: state_d = ST_DIR;
            ST_DIR:  state_d = ST_A2;
            ST_A2:   state_d = ST_A3;
            ST_A3:   state_d = ST_PAR;
            ST_PAR:  state_d = ST_STOP;
            ST_STOP: state_d = ST_PARK;
            ST_PARK: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // field capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hdr    <= '0;
            par_q  <= 1'b0;
            stop_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_PORT: hdr.is_ap   <= din;
                ST_DIR:  hdr.is_read <= din;
                ST_A2:   hdr.ofs[0]  <= din;
                ST_A3:   hdr.ofs[1]  <= din;
                ST_PAR:  par_q       <= din;
                ST_STOP: stop_q      <= din;
                default: ;
            endcase
        end
    end

    // judgement on the park bit
    assign parity_good = ~^{hdr.is_ap, hdr.is_read, hdr.ofs, par_q};
    assign frame_good  = din && !stop_q;
    assign fin_ok      = (state_q == ST_PARK) && frame_good && parity_good;
    assign fin_err     = (state_q == ST_PARK) && !(frame_good && parity_good);

endmodule

// File: rtl/sdbg_sel_reg.sv
module sdbg_sel_reg
    import sdbg_pkg::*;
#(
    parameter int SEL_W   = 32,
    parameter int BANK_W  = 4,
    parameter int APSEL_W = 8
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fin_ok,
    input  logic             fin_err,
    input  req_hdr_t         hdr,
    input  logic             ld,
    input  logic [SEL_W-1:0] wdata,
    output logic [SEL_W-1:0] sel_q
);

    localparam int APSEL_LSB = SEL_W - APSEL_W;
    localparam logic [SEL_W-1:0] RSV_MASK =
        (SEL_W'(1) << APSEL_LSB) - (SEL_W'(1) << (2 * BANK_W));

    logic armed_q;
    logic arm_hit;

    assign arm_hit = !hdr.is_ap && !hdr.is_read && (hdr.ofs == SEL_OFS);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else if (fin_ok) begin
            armed_q <= arm_hit;
        end else if (fin_err) begin
            armed_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)             sel_q <= '0;
        else if (ld && armed_q) sel_q <= wdata & ~RSV_MASK;
    end

endmodule

// File: rtl/sdbg_addr_map.sv
module sdbg_addr_map
    import sdbg_pkg::*;
#(
    parameter int SEL_W   = 32,
    parameter int BANK_W  = 4,
    parameter int APSEL_W = 8,
    parameter int ADDR_W  = BANK_W + 4
)(
    input  req_hdr_t           hdr,
    input  logic [SEL_W-1:0]   sel,
    output logic [ADDR_W-1:0]  addr,
    output logic [APSEL_W-1:0] apsel
);

    logic [BANK_W-1:0] bank;

    always_comb begin
        bank  = hdr.is_ap ? sel[2*BANK_W-1:BANK_W] : sel[BANK_W-1:0];
        addr  = {bank, hdr.ofs, 2'b00};
        apsel = sel[SEL_W-1:SEL_W-APSEL_W];
    end

endmodule

// File: rtl/sdbg_req_resolver.sv
module sdbg_req_resolver
    import sdbg_pkg::*;
#(
    parameter int SEL_W   = 32,
    parameter int BANK_W  = 4,
    parameter int APSEL_W = 8,
    parameter int ADDR_W  = BANK_W + 4
)(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               swdio_in,
    input  logic               sel_ld,
    input  logic [SEL_W-1:0]   sel_wdata,
    output logic               req_valid,
    output logic               req_err,
    output logic               req_is_ap,
    output logic               req_is_read,
    output logic [ADDR_W-1:0]  req_addr,
    output logic [APSEL_W-1:0] req_apsel,
    output logic [SEL_W-1:0]   sel_q
);

    req_hdr_t           hdr;
    logic               fin_ok;
    logic               fin_err;
    logic [ADDR_W-1:0]  addr_c;
    logic [APSEL_W-1:0] apsel_c;

    sdbg_hdr_rx u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .din     (swdio_in),
        .fin_ok  (fin_ok),
        .fin_err (fin_err),
        .hdr     (hdr)
    );

    sdbg_sel_reg #(.SEL_W(SEL_W), .BANK_W(BANK_W), .APSEL_W(APSEL_W)) u_sel (
        .clk     (clk),
        .rst_n   (rst_n),
        .fin_ok  (fin_ok),
        .fin_err (fin_err),
        .hdr     (hdr),
        .ld      (sel_ld),
        .wdata   (sel_wdata),
        .sel_q   (sel_q)
    );

    sdbg_addr_map #(.SEL_W(SEL_W), .BANK_W(BANK_W), .APSEL_W(APSEL_W),
                    .ADDR_W(ADDR_W)) u_map (
        .hdr   (hdr),
        .sel   (sel_q),
        .addr  (addr_c),
        .apsel (apsel_c)
    );

    // output process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_valid   <= 1'b0;
            req_err     <= 1'b0;
            req_is_ap   <= 1'b0;
            req_is_read <= 1'b0;
            req_addr    <= '0;
            req_apsel   <= '0;
        end else begin
            req_valid <= fin_ok;
            req_err   <= fin_err;
            if (fin_ok) begin
                req_is_ap   <= hdr.is_ap;
                req_is_read <= hdr.is_read;
                req_addr    <= addr_c;
                req_apsel   <= apsel_c;
            end
        end
    end

endmodule

// File: rtl/sdbg_req_resolver_chk.sv
module sdbg_req_resolver_chk #(
    parameter int SEL_W   = 32,
    parameter int BANK_W  = 4,
    parameter int APSEL_W = 8,
    parameter int ADDR_W  = BANK_W + 4
)(
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               req_err,
    input logic               req_is_ap,
    input logic               req_is_read,
    input logic [ADDR_W-1:0]  req_addr,
    input logic [APSEL_W-1:0] req_apsel,
    input logic [SEL_W-1:0]   sel_q
);

    a_r10_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid || req_err) |=> !(req_valid || req_err));

    a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_err));

    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> ($stable(req_addr) && $stable(req_is_ap)
                        && $stable(req_is_read) && $stable(req_apsel)));

    a_r3_dp_bank: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_is_ap) |->
            req_addr[ADDR_W-1:ADDR_W-BANK_W] == $past(sel_q[BANK_W-1:0]));

    a_r4_ap_bank: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_is_ap) |->
            (req_addr[ADDR_W-1:ADDR_W-BANK_W] == $past(sel_q[2*BANK_W-1:BANK_W])
             && req_apsel == $past(sel_q[SEL_W-1:SEL_W-APSEL_W])));

    a_r1_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
        req_addr[1:0] == 2'b00);

    a_r9_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        sel_q[SEL_W-APSEL_W-1:2*BANK_W] == '0);

endmodule

bind sdbg_req_resolver sdbg_req_resolver_chk #(
    .SEL_W(SEL_W), .BANK_W(BANK_W), .APSEL_W(APSEL_W), .ADDR_W(ADDR_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_err     (req_err),
    .req_is_ap   (req_is_ap),
    .req_is_read (req_is_read),
    .req_addr    (req_addr),
    .req_apsel   (req_apsel),
    .sel_q       (sel_q)
);

// File: tb/sdbg_req_resolver_test.sv
module sdbg_req_resolver_test;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        swdio_in = 1'b0;
    logic        sel_ld = 1'b0;
    logic [31:0] sel_wdata = '0;
    logic        req_valid, req_err, req_is_ap, req_is_read;
    logic [7:0]  req_addr, req_apsel;
    logic [31:0] sel_q;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #(CLK_P/2) clk = ~clk;

    sdbg_req_resolver uut (
        .clk(clk), .rst_n(rst_n), .swdio_in(swdio_in),
        .sel_ld(sel_ld), .sel_wdata(sel_wdata),
        .req_valid(req_valid), .req_err(req_err),
        .req_is_ap(req_is_ap), .req_is_read(req_is_read),
        .req_addr(req_addr), .req_apsel(req_apsel), .sel_q(sel_q)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // drives one header; returns at the negedge where the strobe is visible
    task automatic send_hdr(input bit ap, input bit rw, input bit a2, input bit a3,
                            input bit flip, input bit stop, input bit park);
        bit [7:0] seq;
        seq = {1'b1, ap, rw, a2, a3, (ap ^ rw ^ a2 ^ a3 ^ flip), stop, park};
        for (int i = 7; i >= 0; i--) begin
            @(negedge clk);
            swdio_in = seq[i];
        end
        @(negedge clk);
        swdio_in = 1'b0;
    endtask

    task automatic try_load(input logic [31:0] d);
        sel_ld = 1'b1;
        sel_wdata = d;
        @(negedge clk);
        sel_ld = 1'b0;
    endtask

    function automatic logic [7:0] exp_addr(input logic [31:0] s, input bit ap,
                                            input bit a2, input bit a3);
        logic [3:0] bank;
        bank = ap ? s[7:4] : s[3:0];
        return {bank, a3, a2, 2'b00};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog act=running exp=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] sel_exp;
        logic [31:0] d;
        logic [7:0]  keep_addr, keep_apsel;
        bit          keep_ap, keep_rd;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R2 reset state
        check("R2 reset outputs", {req_valid, req_err, req_is_ap, req_is_read, req_addr, req_apsel}, '0);
        check("R2 reset select", sel_q, 32'h0);
        sel_exp = 32'h0;

        // R2 debug-port offsets after power-up, R1 bit order
        for (int o = 0; o < 4; o++) begin
            send_hdr(0, 1, o[0], o[1], 0, 0, 1);
            check("R2 dp addr at power-up", {req_valid, req_err, req_addr}, {1'b1, 1'b0, 8'(o * 4)});
        end

        // R1 R3 R4 R9 sweep over banks and all header field combinations
        for (int b = 0; b < 16; b++) begin
            d = {8'(b * 17) ^ 8'h5A, 16'hFFFF, 4'(15 - b), 4'(b)};
            send_hdr(0, 0, 0, 1, 0, 0, 1);
            check("R9 arm write", {req_valid, req_addr[3:0]}, {1'b1, 4'h8});
            try_load(d);
            sel_exp = d & 32'hFF0000FF;
            check("R9 load and reserved zero", sel_q, sel_exp);
            for (int h = 0; h < 16; h++) begin
                send_hdr(h[3], h[2], h[1], h[0], 0, 0, 1);
                check("R3 R4 R1 resolved request",
                      {req_valid, req_err, req_is_ap, req_is_read, req_addr, req_apsel},
                      {1'b1, 1'b0, h[3], h[2], exp_addr(sel_exp, h[3], h[1], h[0]), sel_exp[31:24]});
                @(negedge clk);
                check("R10 strobe one cycle", {req_valid, req_err}, 2'b00);
            end
        end

        // R5 R6 R8 error headers
        keep_addr = req_addr; keep_apsel = req_apsel; keep_ap = req_is_ap; keep_rd = req_is_read;
        send_hdr(0, 1, 1, 0, 1, 0, 1);
        check("R5 parity error", {req_valid, req_err}, 2'b01);
        check("R8 hold on error", {req_is_ap, req_is_read, req_addr, req_apsel},
              {keep_ap, keep_rd, keep_addr, keep_apsel});
        @(negedge clk);
        check("R10 error strobe one cycle", {req_valid, req_err}, 2'b00);
        send_hdr(1, 0, 0, 0, 0, 1, 1);
        check("R6 stop bit error", {req_valid, req_err}, 2'b01);
        send_hdr(1, 0, 0, 0, 0, 0, 0);
        check("R6 park bit error", {req_valid, req_err}, 2'b01);
        check("R8 hold after framing errors", {req_is_ap, req_is_read, req_addr, req_apsel},
              {keep_ap, keep_rd, keep_addr, keep_apsel});

        // R7 idle zeros ignored
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            check("R7 idle no strobe", {req_valid, req_err}, 2'b00);
        end
        send_hdr(0, 1, 1, 1, 0, 0, 1);
        check("R7 header after idle", {req_valid, req_addr}, {1'b1, exp_addr(sel_exp, 0, 1, 1)});

        // R8 hold across a load
        send_hdr(0, 0, 0, 1, 0, 0, 1);
        keep_addr = req_addr;
        try_load(32'h11223344);
        sel_exp = 32'h11000044;
        check("R9 load taken", sel_q, sel_exp);
        check("R8 hold across load", req_addr, keep_addr);

        // R9 load blocked cases
        send_hdr(0, 1, 0, 1, 0, 0, 1);
        try_load(32'hAAAAAAAA);
        check("R9 blocked after dp read", sel_q, sel_exp);
        send_hdr(1, 0, 0, 1, 0, 0, 1);
        try_load(32'hBBBBBBBB);
        check("R9 blocked after ap write", sel_q, sel_exp);
        send_hdr(0, 0, 1, 0, 0, 0, 1);
        try_load(32'hCCCCCCCC);
        check("R9 blocked after dp write offset 4", sel_q, sel_exp);
        send_hdr(0, 0, 0, 1, 0, 0, 1);
        send_hdr(0, 0, 0, 1, 1, 0, 1);
        try_load(32'hDDDDDDDD);
        check("R9 blocked after error", sel_q, sel_exp);

        // R4 check with new bank after load
        send_hdr(1, 1, 1, 0, 0, 0, 1);
        check("R4 ap after reload", {req_addr, req_apsel}, {8'h44, 8'h11});

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule